// File: doc/BRIEF.md
# Six-Bit Accumulator Processor Core

A compact processor with separate program and data stores and a 6-bit data path. It reads 8-bit instructions from a 32-word program store through a read port. It runs each instruction in two clock cycles: one to capture the word and one to carry it out. The data side has an accumulator (register 0), five general registers, one unused slot (index 5) and a read-only input port at index 7 that reflects the switch inputs. Register 4 drives the display output. The carry flag is also brought out.

The core has a controller with three states. `ST_FETCH` latches the word at the program counter into the instruction register and always moves to `ST_EXEC`. `ST_EXEC` performs the operation, updates the registers, flags and program counter, and then moves back to `ST_FETCH`. The one exception is the halt opcode, which moves it to `ST_HALT`. `ST_HALT` has no exit except reset.

Subroutine calls save the call address in a single link register; return resumes at the word after the call. Conditional flow uses skips, which step over exactly one word.

Top module: `acc6_core`

## Requirements
- R1: Reset clears the program counter, the carry and zero flags and all registers, and leaves the core not halted with `imem_addr` = 0.
- R2: Every instruction takes two cycles. The program counter changes only at the end of the execute cycle, and `imem_addr` always shows the program counter.
- R3: Three opcodes change the accumulator or the program counter directly. `11 iiiiii` loads the 6-bit immediate into the accumulator. `101 aaaaa` jumps to address aaaaa. `100 aaaaa` jumps to aaaaa and copies the address of the call word into the link register.
- R4: Return (`00 001 rrr`) loads the program counter with the link register plus one.
- R5: The `01 ooo rrr` group uses ooo to pick the operation. 111 loads register rrr into the accumulator. 110 stores the accumulator into rrr. 101 adds rrr to the accumulator and 100 subtracts rrr from it. 011, 010 and 001 perform AND, OR and XOR with rrr into the accumulator. 000 inverts register rrr in place. The word `01 110 000` acts as a no-operation.
- R6: Add sets carry to the carry-out of bit 5. Subtract sets carry when no borrow occurs (accumulator >= register) and clears it otherwise.
- R7: The `00 ooo rrr` group acts on register rrr. 111 increments it, 110 decrements it and 100 clears it. 011 rotates it left through carry (the old bit 5 goes to carry and the old carry to bit 0). 010 rotates it right through carry (the old bit 0 goes to carry and the old carry to bit 5).
- R8: Zero is set when the result is zero and cleared otherwise. Only load-register, add, subtract, AND, OR, XOR, invert, increment, decrement and clear change it. Immediate load, store, the rotates, decrement-and-skip and the `00 000 xxx` controls leave it unchanged.
- R9: `00 101 rrr` decrements register rrr and skips the next word if the result is zero.
- R10: The `00 000 xxx` controls are selected by xxx. 111 clears carry and 110 sets carry. 101 skips if carry is clear and 100 skips if carry is set. 011 skips if zero is set and 010 skips if zero is clear. 001 writes the carry value (0 or 1) into the accumulator.
- R11: `00 000 000` halts. `halted` then stays 1 and `imem_addr` stays fixed until reset.
- R12: A skip adds two to the 5-bit program counter modulo 32, so a skip taken at address 31 resumes at address 1.
- R13: Register 7 reads `sw_in`, and writes to it are ignored. Slot 5 reads as zero and ignores writes.
- R14: `disp_out` shows register 4 and `carry_out` shows the carry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 5 | Program store read address (program counter) |
| imem_data | input | 8 | Instruction word at `imem_addr` |
| sw_in | input | 6 | Switch inputs, readable as register 7 |
| disp_out | output | 6 | Contents of register 4 |
| carry_out | output | 1 | Carry flag |
| halted | output | 1 | High once the halt opcode has executed |

## Verification
The hardest cases to reach are the ones where a flag must survive an instruction that is not allowed to touch it. One example is zero staying clear across a decrement-and-skip whose own result is zero. The other is a skip taken from the last program address. The bench builds short programs in its model of the program store to reach them. A counting loop ends on decrement-and-skip and is followed by a skip-if-zero. A jump lands at address 31 right after a clear, so the skip there must wrap to address 1. A wrong flag update or a missing wrap then shows up as a different display value or as a program that never halts.

// File: rtl/acc6_pkg.sv
package acc6_pkg;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_HALT
    } core_state_e;

    typedef enum logic [3:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_INV,
        ALU_INC,
        ALU_DEC,
        ALU_CLR,
        ALU_ROL,
        ALU_ROR
    } alu_op_e;

    typedef enum logic [1:0] {
        WD_ALU,
        WD_ACC,
        WD_IMM,
        WD_CARRY
    } wdata_sel_e;

    typedef enum logic [1:0] {
        CF_KEEP,
        CF_ALU,
        CF_ZERO,
        CF_ONE
    } carry_sel_e;

endpackage

// File: rtl/acc6_alu.sv
module acc6_alu
    import acc6_pkg::*;
#(
    parameter int DW = 6
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] y,
    output logic          cout,
    output logic          zero
);
    logic [DW:0] sum;
    logic [DW:0] diff;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, a} - {1'b0, b};
        cout = cin;
        unique case (op)
            ALU_PASS: y = b;
            ALU_ADD:  begin y = sum[DW-1:0];  cout = sum[DW];   end
            ALU_SUB:  begin y = diff[DW-1:0]; cout = ~diff[DW]; end
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_INV:  y = ~b;
            ALU_INC:  y = b + DW'(1);
            ALU_DEC:  y = b - DW'(1);
            ALU_CLR:  y = '0;
            ALU_ROL:  begin y = {b[DW-2:0], cin}; cout = b[DW-1]; end
            ALU_ROR:  begin y = {cin, b[DW-1:1]}; cout = b[0];    end
            default:  y = b;
        endcase
        zero = (y == '0);
    end

    // carry semantics checked against a wider arithmetic view
    always_comb begin
        if (op == ALU_SUB)
            assert_sub_noborrow_R6: assert (cout == (a >= b));
        if (op == ALU_ADD)
            assert_add_carryout_R6: assert (cout == ((32'(a) + 32'(b)) >= (32'd1 << DW)));
    end

endmodule

// File: rtl/acc6_regfile.sv
module acc6_regfile #(
    parameter int DW       = 6,
    parameter int NREG     = 8,
    parameter int IN_IDX   = 7,
    parameter int GAP_IDX  = 5,
    parameter int DISP_IDX = 4,
    localparam int RAW     = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] raddr,
    output logic [DW-1:0]  rdata,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [DW-1:0]  sw_in,
    output logic [DW-1:0]  acc,
    output logic [DW-1:0]  disp
);
    logic [DW-1:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == IN_IDX) begin : g_in
            assign q[i] = sw_in;
        end else if (i == GAP_IDX) begin : g_gap
            assign q[i] = '0;
        end else begin : g_store
            logic [DW-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          r <= '0;
                else if (we && waddr == RAW'(i))     r <= wdata;
            end
            assign q[i] = r;
        end
    end

    assign rdata = q[raddr];
    assign acc   = q[0];
    assign disp  = q[DISP_IDX];

endmodule

// File: rtl/acc6_core.sv
module acc6_core
    import acc6_pkg::*;
#(
    parameter int DW = 6,
    parameter int AW = 5,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] imem_addr,
    input  logic [IW-1:0] imem_data,
    input  logic [DW-1:0] sw_in,
    output logic [DW-1:0] disp_out,
    output logic          carry_out,
    output logic          halted
);
    localparam int NREG = 8;
    localparam int RAW  = $clog2(NREG);

    core_state_e   state, state_nx;
    logic [AW-1:0] pc, lr, pc_nx;
    logic [IW-1:0] ir;
    logic          cflag, zflag;

    // decoded controls
    alu_op_e       alu_op;
    wdata_sel_e    wd_sel;
    carry_sel_e    c_sel;
    logic          reg_we, z_upd, do_skip, do_jump, do_call, do_ret, do_halt;
    logic [RAW-1:0] waddr;

    logic [1:0]    grp;
    logic [2:0]    fn;
    logic [RAW-1:0] rsel;
    logic [DW-1:0] rdata, acc, alu_y, wdata;
    logic          alu_c, alu_z;

    assign grp  = ir[7:6];
    assign fn   = ir[5:3];
    assign rsel = ir[RAW-1:0];

    acc6_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .raddr(rsel), .rdata(rdata),
        .we(reg_we && state == ST_EXEC), .waddr(waddr), .wdata(wdata),
        .sw_in(sw_in), .acc(acc), .disp(disp_out)
    );

    acc6_alu #(.DW(DW)) u_alu (
        .op(alu_op), .a(acc), .b(rdata), .cin(cflag),
        .y(alu_y), .cout(alu_c), .zero(alu_z)
    );

    // instruction decode
    always_comb begin
        alu_op  = ALU_PASS;
        wd_sel  = WD_ALU;
        c_sel   = CF_KEEP;
        reg_we  = 1'b0;
        waddr   = rsel;
        z_upd   = 1'b0;
        do_skip = 1'b0;
        do_jump = 1'b0;
        do_call = 1'b0;
        do_ret  = 1'b0;
        do_halt = 1'b0;
        unique case (grp)
            2'b11: begin
                reg_we = 1'b1; waddr = '0; wd_sel = WD_IMM;
            end
            2'b10: begin
                do_jump = 1'b1;
                do_call = ~ir[5];
            end
            2'b01: begin
                unique case (fn)
                    3'b111: begin alu_op = ALU_PASS; reg_we = 1'b1; waddr = '0; z_upd = 1'b1; end
                    3'b110: begin wd_sel = WD_ACC; reg_we = 1'b1; end
                    3'b101: begin alu_op = ALU_ADD; reg_we = 1'b1; waddr = '0; z_upd = 1'b1; c_sel = CF_ALU; end
                    3'b100: begin alu_op = ALU_SUB; reg_we = 1'b1; waddr = '0; z_upd = 1'b1; c_sel = CF_ALU; end
                    3'b011: begin alu_op = ALU_AND; reg_we = 1'b1; waddr = '0; z_upd = 1'b1; end
                    3'b010: begin alu_op = ALU_OR;  reg_we = 1'b1; waddr = '0; z_upd = 1'b1; end
                    3'b001: begin alu_op = ALU_XOR; reg_we = 1'b1; waddr = '0; z_upd = 1'b1; end
                    default: begin alu_op = ALU_INV; reg_we = 1'b1; z_upd = 1'b1; end
                endcase
            end
            default: begin
                unique case (fn)
                    3'b111: begin alu_op = ALU_INC; reg_we = 1'b1; z_upd = 1'b1; end
                    3'b110: begin alu_op = ALU_DEC; reg_we = 1'b1; z_upd = 1'b1; end
                    3'b101: begin alu_op = ALU_DEC; reg_we = 1'b1; do_skip = alu_z; end
                    3'b100: begin alu_op = ALU_CLR; reg_we = 1'b1; z_upd = 1'b1; end
                    3'b011: begin alu_op = ALU_ROL; reg_we = 1'b1; c_sel = CF_ALU; end
                    3'b010: begin alu_op = ALU_ROR; reg_we = 1'b1; c_sel = CF_ALU; end
                    3'b001: do_ret = 1'b1;
                    default: begin
                        unique case (ir[2:0])
                            3'b111: c_sel = CF_ZERO;
                            3'b110: c_sel = CF_ONE;
                            3'b101: do_skip = ~cflag;
                            3'b100: do_skip = cflag;
                            3'b011: do_skip = zflag;
                            3'b010: do_skip = ~zflag;
                            3'b001: begin reg_we = 1'b1; waddr = '0; wd_sel = WD_CARRY; end
                            default: do_halt = 1'b1;
                        endcase
                    end
                endcase
            end
        endcase
    end

    always_comb begin
        unique case (wd_sel)
            WD_ACC:   wdata = acc;
            WD_IMM:   wdata = ir[DW-1:0];
            WD_CARRY: wdata = {{(DW-1){1'b0}}, cflag};
            default:  wdata = alu_y;
        endcase
    end

    always_comb begin
        if (do_jump)      pc_nx = ir[AW-1:0];
        else if (do_ret)  pc_nx = lr + AW'(1);
        else if (do_skip) pc_nx = pc + AW'(2);
        else              pc_nx = pc + AW'(1);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: state_nx = ST_EXEC;
            ST_EXEC:  state_nx = do_halt ? ST_HALT : ST_FETCH;
            default:  state_nx = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            lr    <= '0;
            ir    <= '0;
            cflag <= 1'b0;
            zflag <= 1'b0;
        end else if (state == ST_FETCH) begin
            ir <= imem_data;
        end else if (state == ST_EXEC) begin
            pc <= pc_nx;
            if (do_call) lr <= pc;
            if (z_upd)   zflag <= alu_z;
            unique case (c_sel)
                CF_ALU:  cflag <= alu_c;
                CF_ZERO: cflag <= 1'b0;
                CF_ONE:  cflag <= 1'b1;
                default: cflag <= cflag;
            endcase
        end
    end

    // outputs
    always_comb begin
        imem_addr = pc;
        carry_out = cflag;
        halted    = (state == ST_HALT);
    end

    assert_pc_hold_in_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> $stable(pc));
    assert_call_links_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && do_call) |=> (lr == $past(pc)));
    assert_return_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && do_ret) |=> (pc == AW'($past(lr) + AW'(1))));
    assert_halt_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));
    assert_skip_wraps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && do_skip && !do_jump && !do_ret) |=> (pc == AW'($past(pc) + AW'(2))));

endmodule

// File: tb/sim_acc6_core.sv
module sim_acc6_core;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] imem_addr;
    logic [7:0] imem_data;
    logic [5:0] sw_in = '0;
    logic [5:0] disp_out;
    logic       carry_out;
    logic       halted;

    logic [7:0] rom [32];
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign imem_data = rom[imem_addr];

    acc6_core u0 (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .sw_in(sw_in), .disp_out(disp_out), .carry_out(carry_out), .halted(halted)
    );

    // {op3, a6, b6, expected6, expected_carry1}
    localparam logic [21:0] VEC [NVEC] = '{
        {3'b101, 6'd5,  6'd7,  6'd12, 1'b0},
        {3'b101, 6'd60, 6'd10, 6'd6,  1'b1},
        {3'b100, 6'd20, 6'd7,  6'd13, 1'b1},
        {3'b100, 6'd7,  6'd20, 6'd51, 1'b0},
        {3'b100, 6'd9,  6'd9,  6'd0,  1'b1},
        {3'b011, 6'd42, 6'd15, 6'd10, 1'b0},
        {3'b010, 6'd42, 6'd15, 6'd47, 1'b0},
        {3'b001, 6'd42, 6'd15, 6'd37, 1'b0},
        {3'b111, 6'd3,  6'd33, 6'd33, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 32; i++) rom[i] = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_prog();
        do_reset();
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (halted) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [4:0] held;
        clear_rom();
        // R1 reset state
        do_reset();
        chk("R1 imem_addr", int'(imem_addr), 0);
        chk("R1 disp", int'(disp_out), 0);
        chk("R1 carry", int'(carry_out), 0);
        chk("R1 halted", int'(halted), 0);

        // R5 R6 table walk
        for (int v = 0; v < NVEC; v++) begin
            clear_rom();
            rom[0] = 8'hC0 | {2'b00, VEC[v][12:7]};
            rom[1] = 8'h71;
            rom[2] = 8'hC0 | {2'b00, VEC[v][18:13]};
            rom[3] = {2'b01, VEC[v][21:19], 3'b001};
            rom[4] = 8'h74;
            rom[5] = 8'h00;
            run_prog();
            chk("R5 alu result", int'(disp_out), int'(VEC[v][6:1]));
            chk("R6 carry", int'(carry_out), int'(VEC[v][0]));
        end

        // R3 R4 call and return
        clear_rom();
        rom[0] = 8'h8A; rom[1] = 8'h7B; rom[2] = 8'h74; rom[3] = 8'h00;
        rom[10] = 8'hC5; rom[11] = 8'h73; rom[12] = 8'h08;
        run_prog();
        chk("R4 return to call+1", int'(disp_out), 5);
        chk("R11 halted", int'(halted), 1);
        held = imem_addr;
        repeat (5) @(negedge clk);
        chk("R11 addr frozen", int'(imem_addr), int'(held));
        do_reset();
        chk("R1 regs cleared", int'(disp_out), 0);

        // R9 R8 decrement-and-skip loop, zero kept
        clear_rom();
        rom[0] = 8'hC3; rom[1] = 8'h72; rom[2] = 8'h3C; rom[3] = 8'h2A;
        rom[4] = 8'hA2; rom[5] = 8'h03; rom[6] = 8'h3C; rom[7] = 8'h00;
        run_prog();
        chk("R9 dsz loop, R8 z kept", int'(disp_out), 4);

        // R7 rotates through carry
        clear_rom();
        rom[0] = 8'h06; rom[1] = 8'hE0; rom[2] = 8'h18; rom[3] = 8'h10;
        rom[4] = 8'h10; rom[5] = 8'h74; rom[6] = 8'h00;
        run_prog();
        chk("R7 rotate value", int'(disp_out), 48);
        chk("R7 rotate carry", int'(carry_out), 0);

        // R10 carry controls and copy
        clear_rom();
        rom[0] = 8'h06; rom[1] = 8'h04; rom[2] = 8'h00; rom[3] = 8'h01;
        rom[4] = 8'h05; rom[5] = 8'h07; rom[6] = 8'h74; rom[7] = 8'h00;
        run_prog();
        chk("R10 copy carry", int'(disp_out), 1);
        chk("R14 carry out", int'(carry_out), 0);

        // R13 input port read-only
        clear_rom();
        sw_in = 6'd21;
        rom[0] = 8'hC9; rom[1] = 8'h77; rom[2] = 8'h7F; rom[3] = 8'h74; rom[4] = 8'h00;
        run_prog();
        chk("R13 reg7 reads switches", int'(disp_out), 21);
        sw_in = 6'd0;

        // R13 slot 5 ignores writes
        clear_rom();
        rom[0] = 8'hDC; rom[1] = 8'h75; rom[2] = 8'h7D; rom[3] = 8'h74; rom[4] = 8'h00;
        run_prog();
        chk("R13 slot5 reads zero", int'(disp_out), 0);

        // R12 skip wrap at 31
        clear_rom();
        rom[0] = 8'hBE; rom[30] = 8'h20; rom[31] = 8'h03;
        rom[1] = 8'hEA; rom[2] = 8'h74; rom[3] = 8'h00;
        run_prog();
        chk("R12 skip wrap", int'(disp_out), 42);

        // R8 invert sets zero, skip-if-not-zero falls through
        clear_rom();
        rom[0] = 8'hFF; rom[1] = 8'h73; rom[2] = 8'h43; rom[3] = 8'h02;
        rom[4] = 8'hC7; rom[5] = 8'h74; rom[6] = 8'h00;
        run_prog();
        chk("R8 invert zero", int'(disp_out), 7);

        // R8 R5 immediate load and no-op keep zero
        clear_rom();
        rom[0] = 8'h21; rom[1] = 8'hC5; rom[2] = 8'h70; rom[3] = 8'h03;
        rom[4] = 8'h00; rom[5] = 8'h74; rom[6] = 8'h00;
        run_prog();
        chk("R8 ldi keeps zero", int'(disp_out), 5);

        // R2 two cycles per instruction
        clear_rom();
        rom[0] = 8'hC1; rom[1] = 8'hC2;
        do_reset();
        @(negedge clk);
        chk("R2 addr after fetch", int'(imem_addr), 0);
        @(negedge clk);
        chk("R2 addr after exec", int'(imem_addr), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule